// File: doc/BRIEF.md
# Rotating-Key Shift-XOR Tag Generator

This block builds an 8-bit authentication tag over a stream of ciphertext bytes as they arrive. For each accepted byte, the top bit of a tag key decides whether the byte is first moved left by a fixed number of positions. The byte, moved or not, is then folded into a running accumulator by XOR, and the key rotates left by one position. Each key bit is therefore used again after every `KEY_W` bytes.

A message opens with a start strobe. The strobe zeroes the accumulator, since no initialisation vector exists, and loads the key. Bytes are then offered with a valid strobe. The final byte carries a last flag. One clock after that byte, the finished tag appears on the output together with a single-cycle done pulse. The tag stays on the output until the next message completes.

Top module: `tag_gen`

## Requirements
- R1: After reset, `tag_o` is 0x00 and `done_o` is low.
- R2: When the current key's most significant bit is 1, the byte is shifted left by `SHIFT` positions (default 2) before the XOR. Bits moved past bit 7 are dropped. With key 4'b1000, the single byte 0xC3 gives the tag 0x0C.
- R3: When the current key's most significant bit is 0, the byte enters the XOR unshifted. With key 4'b0000, the single byte 0xC3 gives the tag 0xC3.
- R4: Bytes are folded in arrival order by XOR into an accumulator. The first byte after a start is XORed with 0x00.
- R5: The key rotates left by one bit after each accepted byte, so bit `KEY_W-2` becomes the next deciding bit. After `KEY_W` bytes the original key is back.
- R6: `start_i` clears the accumulator and loads `key_i`, discarding any message in progress. If `valid_i` is high in the same cycle, that byte is absorbed as the first byte of the new message, using the bit 3 of the newly loaded key.
- R7: A byte with `valid_i` and `last_i` both high causes `tag_o` to show the final accumulator value on the next clock, and `done_o` to be high for exactly that cycle. At all other times `tag_o` holds its value.
- R8: While `valid_i` is low, no byte is absorbed, the key does not rotate, and `last_i` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a new message: clear accumulator, load key |
| key_i | input | KEY_W | Tag key loaded on start |
| valid_i | input | 1 | Byte on `data_i` is to be absorbed |
| data_i | input | DATA_W | Ciphertext byte |
| last_i | input | 1 | Qualifies the valid byte as the final one |
| tag_o | output | DATA_W | Most recent completed tag |
| done_o | output | 1 | One-cycle pulse when `tag_o` is updated |

## Verification
Two functions can coincide in one cycle: opening a message and absorbing a byte. The bench raises `start_i` together with `valid_i`, including one single-byte message that also has `last_i` high. It also restarts a message partway through. A scoreboard model computes the expected tag, assuming the byte uses the freshly loaded key and a zero accumulator. The tag popped at each done pulse must match. A stale key bit or leftover accumulator contents would show up as a wrong tag.

// File: rtl/tag_pkg.sv
package tag_pkg;
  localparam int unsigned TAG_W     = 8;
  localparam int unsigned KEY_W_DEF = 4;
  localparam int unsigned SHIFT_DEF = 2;
endpackage

// File: rtl/tag_key_rot.sv
module tag_key_rot #(
  parameter int unsigned KEY_W = tag_pkg::KEY_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [KEY_W-1:0] key_i,
  input  logic             adv_i,
  output logic             msb_o
);
  localparam int unsigned MSB = KEY_W - 1;

  logic [KEY_W-1:0] key_q, key_cur;

  function automatic logic [KEY_W-1:0] rotl(input logic [KEY_W-1:0] k);
    if (KEY_W == 1) return k;
    return {k[KEY_W-2:0], k[MSB]};
  endfunction

  // freshly loaded key is visible to a byte arriving with the start strobe
  assign key_cur = load_i ? key_i : key_q;
  assign msb_o   = key_cur[MSB];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     key_q <= '0;
    else if (adv_i)  key_q <= rotl(key_cur);
    else if (load_i) key_q <= key_i;
  end

  assert_key_rotate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i) |=> key_q == rotl($past(key_q)));
  assert_key_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !load_i) |=> $stable(key_q));
  assert_key_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !adv_i) |=> key_q == $past(key_i));
endmodule

// File: rtl/tag_mix.sv
module tag_mix #(
  parameter int unsigned DATA_W = tag_pkg::TAG_W,
  parameter int unsigned SHIFT  = tag_pkg::SHIFT_DEF
) (
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              shift_en_i,
  output logic [DATA_W-1:0] acc_o
);
  logic [DATA_W-1:0] shifted;

  generate
    if (SHIFT >= DATA_W) begin : g_all_out
      assign shifted = '0;
    end else if (SHIFT == 0) begin : g_none
      assign shifted = data_i;
    end else begin : g_shift
      assign shifted = {data_i[DATA_W-1-SHIFT:0], {SHIFT{1'b0}}};
    end
  endgenerate

  assign acc_o = acc_i ^ (shift_en_i ? shifted : data_i);
endmodule

// File: rtl/tag_gen.sv
module tag_gen #(
  parameter int unsigned DATA_W = tag_pkg::TAG_W,
  parameter int unsigned KEY_W  = tag_pkg::KEY_W_DEF,
  parameter int unsigned SHIFT  = tag_pkg::SHIFT_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [KEY_W-1:0]  key_i,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              last_i,
  output logic [DATA_W-1:0] tag_o,
  output logic              done_o
);
  logic [DATA_W-1:0] acc_q, acc_base, acc_nxt, tag_q;
  logic              shift_en, done_q, fin;

  assign fin      = valid_i && last_i;
  assign acc_base = start_i ? '0 : acc_q;

  tag_key_rot #(.KEY_W(KEY_W)) i_key (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(start_i),
    .key_i (key_i),
    .adv_i (valid_i),
    .msb_o (shift_en)
  );

  tag_mix #(.DATA_W(DATA_W), .SHIFT(SHIFT)) i_mix (
    .acc_i     (acc_base),
    .data_i    (data_i),
    .shift_en_i(shift_en),
    .acc_o     (acc_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      tag_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (valid_i)      acc_q <= acc_nxt;
      else if (start_i) acc_q <= '0;
      if (fin)          tag_q <= acc_nxt;
      done_q <= fin;
    end
  end

  assign tag_o  = tag_q;
  assign done_o = done_q;

  assert_done_after_last_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin |=> done_o);
  assert_no_spurious_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fin |=> !done_o);
  assert_tag_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fin |=> $stable(tag_o));
  assert_start_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !valid_i) |=> acc_q == '0);
  assert_idle_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && !start_i) |=> $stable(acc_q));
endmodule

// File: tb/test_tag_gen.sv
module test_tag_gen;
  localparam int KW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0, valid = 1'b0, last = 1'b0;
  logic [KW-1:0] key = '0;
  logic [7:0]    data = '0;
  logic [7:0]    tag;
  logic          done;

  int n_run = 0, n_fail = 0;
  logic [7:0] exp_q[$];
  logic [7:0] m_acc = '0;
  logic [KW-1:0] m_key = '0;

  always #2.5 clk = ~clk;

  tag_gen i_tag_gen (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .key_i(key),
    .valid_i(valid), .data_i(data), .last_i(last),
    .tag_o(tag), .done_o(done)
  );

  // reference model applied in driving order
  task automatic drive(input logic st, input logic [KW-1:0] k,
                       input logic v, input logic [7:0] d, input logic l);
    logic [7:0] s;
    @(negedge clk);
    start = st; key = k; valid = v; data = d; last = l;
    if (st) begin m_acc = '0; m_key = k; end
    if (v) begin
      s = d << 2;
      m_acc = m_acc ^ (m_key[KW-1] ? s : d);
      m_key = {m_key[KW-2:0], m_key[KW-1]};
      if (l) exp_q.push_back(m_acc);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, key, 1'b0, 8'hA5, 1'b1);
  endtask

  task automatic send_msg(input logic [KW-1:0] k, input logic [7:0] b[],
                          input logic merge);
    if (!merge) drive(1'b1, k, 1'b0, 8'h00, 1'b0);
    for (int i = 0; i < b.size(); i++)
      drive(merge && i == 0, k, 1'b1, b[i], i == b.size() - 1);
    drive(1'b0, k, 1'b0, 8'h00, 1'b0);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // monitor: pop expected tag at every done pulse
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        n_run++; n_fail++;
        $display("FAIL R7: unexpected done, actual tag %02h expected no pulse", tag);
      end else begin
        check("R4/R7 scoreboard tag", tag, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (40000) @(posedge clk);
    n_fail++;
    $display("FAIL R7 watchdog: actual hang expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] prev;
    repeat (3) @(negedge clk);
    check("R1 reset tag", tag, 8'h00);
    check("R1 reset done", {7'd0, done}, 8'h00);
    rst_n = 1'b1;

    // R2: shifted single byte, top bits dropped
    send_msg(4'b1000, '{8'hC3}, 1'b0);
    @(negedge clk);
    check("R2 shifted byte", tag, 8'h0C);
    // R3: unshifted single byte
    send_msg(4'b0000, '{8'hC3}, 1'b0);
    @(negedge clk);
    check("R3 unshifted byte", tag, 8'hC3);

    // R4/R5: multi-byte messages, key wraps after KW bytes
    send_msg(4'b1010, '{8'h43, 8'h6F, 8'h6D, 8'h70, 8'h41, 8'h72, 8'h63, 8'h68}, 1'b0);
    send_msg(4'b1111, '{8'hFF, 8'h80, 8'h01, 8'h7E, 8'hC0}, 1'b0);
    send_msg(4'b0001, '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66}, 1'b0);
    // R5 hand value: key 0100 -> shifts only second byte: 0x01 ^ (0x01<<2) = 0x05
    send_msg(4'b0100, '{8'h01, 8'h01}, 1'b0);
    @(negedge clk);
    check("R5 rotated key bit", tag, 8'h05);

    // R6: start with valid in same cycle, incl. single-byte message
    send_msg(4'b1001, '{8'h3C, 8'h5A, 8'h99}, 1'b1);
    send_msg(4'b1000, '{8'hC3}, 1'b1);
    @(negedge clk);
    check("R6 start with byte", tag, 8'h0C);
    // R6: restart mid-message discards prior bytes
    drive(1'b1, 4'b0110, 1'b0, 8'h00, 1'b0);
    drive(1'b0, 4'b0110, 1'b1, 8'hEE, 1'b0);
    drive(1'b0, 4'b0110, 1'b1, 8'h77, 1'b0);
    send_msg(4'b0011, '{8'h12, 8'h34, 8'h56}, 1'b1);

    // R8: gaps with last high but valid low; key and acc must not move
    drive(1'b1, 4'b1100, 1'b0, 8'h00, 1'b0);
    drive(1'b0, 4'b1100, 1'b1, 8'h0F, 1'b0);
    idle(4);
    prev = tag;
    check("R8 no tag change while idle", tag, prev);
    drive(1'b0, 4'b1100, 1'b1, 8'h0F, 1'b0);
    idle(3);
    drive(1'b0, 4'b1100, 1'b1, 8'h81, 1'b1);
    drive(1'b0, 4'b1100, 1'b0, 8'h00, 1'b0);
    @(negedge clk);
    // 0x3C ^ 0x3C ^ 0x81 (third byte uses key bit 1 = 0)
    check("R8 gaps ignored", tag, 8'h81);

    // R7: back-to-back last bytes give consecutive pulses
    drive(1'b1, 4'b0000, 1'b1, 8'h10, 1'b1);
    drive(1'b1, 4'b0000, 1'b1, 8'h20, 1'b1);
    drive(1'b0, 4'b0000, 1'b0, 8'h00, 1'b0);
    repeat (3) @(negedge clk);
    check("R7 tag held", tag, 8'h20);

    n_run++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R7: missing done pulses, actual %0d pending expected 0", exp_q.size());
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule